// File: doc/BRIEF.md
# Secure Memory Region Access Filter

This block guards one memory port. Every read or write request is compared against a small table of programmed address windows. The request's security state, its 4-bit non-secure master ID and its direction then decide whether it may proceed. A permitted request is forwarded to the memory side without change. A denied request never reaches memory, and its read data comes back as zero. Depending on a 2-bit action setting, the block also flags an error on the response, raises an interrupt line, or does both.

The first denied request is recorded in fail registers: its address, a control word and the master ID. Any later denial before software clears the status only sets a sticky overrun flag. Software reaches the region table, the action setting, the status and clear words and a read-only build word through a simple word-addressed configuration port. The response to each accepted request appears one clock after acceptance, under a valid/ready handshake.

Top module: `mem_region_filter`

## Requirements
- R1: Region 0 spans the whole address space and always matches. A region r≥1 matches when its enable (attribute bit 0) is set and base ≤ address ≤ top, both ends inclusive. When several regions match, the highest-numbered one decides.
- R2: A secure request is allowed only when the deciding region's attribute bit 30 (secure read) or bit 31 (secure write) is set for its direction.
- R3: A non-secure request with master ID n is allowed only when bit n (read) or bit 16+n (write) of the deciding region's ID-access word is set.
- R4: The action word bits [1:0] select what a denial signals: 0 nothing, 1 an error response, 2 an interrupt, 3 both. The error is flagged on the response of the denied request itself, using the action value in force when that request was accepted.
- R5: A permitted request is forwarded to the memory port with its address, direction and write data unchanged. A denied request is not forwarded. A read response carries the memory data when permitted and zero when denied. A write response carries zero data.
- R6: The first denial captures its address (word 4), a control word (word 5) with bit 24 set for a write, bit 21 set for non-secure and bit 20 set for privileged, and its master ID (word 6, bits [3:0]).
- R7: Status word 2 shows the fail status in bit 0 and the overrun flag in bit 8. A denial while the status is set sets overrun and leaves the captured data unchanged. Writing 1 to bit 0 or bit 8 of clear word 3 clears the matching flag. A denial in the same cycle as a status clear is captured as a first denial. The interrupt is asserted while the status is set and action bit 1 is set.
- R8: Build word 0 reads the region count minus one in bits [4:0] and the address width minus one in bits [13:8].
- R9: The response is valid exactly one clock after a request is accepted. A request is accepted when it is valid while `req_ready` is high, and `req_ready` is high unless a response is pending with `rsp_ready` low.
- R10: After reset, all permissions, region enables, bases, tops and the action are zero, and the status, overrun and responses are clear, so every request is denied without signalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure request |
| req_priv | input | 1 | 1 = privileged request |
| req_id | input | 4 | Non-secure master ID |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Read data, zero when denied or a write |
| rsp_err | output | 1 | Error response |
| mem_en | output | 1 | Forwarded access strobe |
| mem_we | output | 1 | Forwarded direction |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | DW | Forwarded write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read strobe, held until the next |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | Configuration write |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| irq | output | 1 | Violation interrupt |

## Verification
A wrong region pick or a wrong permission bit shows up in the same cycle as a wrong `mem_en` strobe, and one clock later as a zeroed or error response that should not be there. A fail register that is overwritten by a second denial, or an overrun flag that fails to stick, shows only when the fail or status words are read back. It also changes `irq` on the clock after the denial or after the clear. The reference model is compared against every output on every clock, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/rfilt_pkg.sv
package rfilt_pkg;
  // Configuration word map (word addresses)
  localparam int REG_BUILD  = 0;
  localparam int REG_ACTION = 1;
  localparam int REG_STATUS = 2;
  localparam int REG_CLEAR  = 3;
  localparam int REG_FADDR  = 4;
  localparam int REG_FCTL   = 5;
  localparam int REG_FID    = 6;
  localparam int REG_RGN0   = 16;
  localparam int RGN_STRIDE = 4;

  // Inclusive window test on zero-extended operands
  function automatic logic in_window(logic [63:0] a, logic [63:0] lo, logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Permission of one access against the deciding region
  function automatic logic grant(logic sec, logic wr, logic [3:0] id,
                                 logic srd, logic swr, logic [31:0] ida);
    if (sec) return wr ? swr : srd;
    return wr ? ida[5'd16 + {1'b0, id}] : ida[{1'b0, id}];
  endfunction

  // Fail control word: write at 24, non-secure at 21, privileged at 20
  function automatic logic [31:0] fail_ctl(logic wr, logic sec, logic priv);
    logic [31:0] w;
    w = '0;
    w[24] = wr;
    w[21] = ~sec;
    w[20] = priv;
    return w;
  endfunction

  function automatic logic [31:0] build_word(int nr, int aw);
    logic [31:0] w;
    w = '0;
    w[4:0]  = 5'(nr - 1);
    w[13:8] = 6'(aw - 1);
    return w;
  endfunction
endpackage

// File: rtl/rfilt_match.sv
module rfilt_match
  import rfilt_pkg::*;
#(
  parameter int NR = 4,
  parameter int AW = 32,
  parameter int IW = 2
) (
  input  logic [AW-1:0]         addr,
  input  logic [NR-1:0][AW-1:0] base,
  input  logic [NR-1:0][AW-1:0] top,
  input  logic [NR-1:0]         en,
  output logic [IW-1:0]         win
);
  logic [NR-1:0] hit;

  for (genvar r = 0; r < NR; r++) begin : g_hit
    assign hit[r] = en[r] & in_window(64'(addr), 64'(base[r]), 64'(top[r]));
  end

  // Highest-numbered matching region decides
  function automatic logic [IW-1:0] last_set(logic [NR-1:0] v);
    logic [IW-1:0] k;
    k = '0;
    for (int i = 0; i < NR; i++) if (v[i]) k = IW'(i);
    return k;
  endfunction

  assign win = last_set(hit);
endmodule

// File: rtl/rfilt_perm.sv
module rfilt_perm
  import rfilt_pkg::*;
(
  input  logic        secure,
  input  logic        write,
  input  logic [3:0]  id,
  input  logic        srd,
  input  logic        swr,
  input  logic [31:0] ida,
  output logic        allow
);
  assign allow = grant(secure, write, id, srd, swr, ida);
endmodule

// File: rtl/rfilt_faillog.sv
module rfilt_faillog
  import rfilt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic          secure,
  input  logic          priv,
  input  logic [3:0]    id,
  input  logic          clr_stat,
  input  logic          clr_ovr,
  output logic          status,
  output logic          overrun,
  output logic [AW-1:0] f_addr,
  output logic [31:0]   f_ctl,
  output logic [3:0]    f_id,
  output logic          first_hit
);
  logic held;
  assign held      = status & ~clr_stat;
  assign first_hit = viol & ~held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= 1'b0;
      overrun <= 1'b0;
      f_addr  <= '0;
      f_ctl   <= '0;
      f_id    <= '0;
    end else begin
      status  <= held | viol;
      overrun <= (overrun & ~clr_ovr) | (viol & held);
      if (first_hit) begin
        f_addr <= addr;
        f_ctl  <= fail_ctl(write, secure, priv);
        f_id   <= id;
      end
    end
  end
endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter
  import rfilt_pkg::*;
#(
  parameter int NR     = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic              req_priv,
  input  logic [3:0]        req_id,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq
);
  localparam int IW = (NR > 1) ? $clog2(NR) : 1;

  logic [NR-1:0][AW-1:0] base_q, top_q;
  logic [NR-1:0][31:0]   ida_q;
  logic [NR-1:0]         en_q, srd_q, swr_q;
  logic [1:0]            act_q;
  logic                  cfg_wr, clr_stat, clr_ovr;
  logic [IW-1:0]         win;
  logic                  allow, accept, viol, first_hit;
  logic                  fail_status, fail_overrun;
  logic [AW-1:0]         f_addr;
  logic [31:0]           f_ctl;
  logic [3:0]            f_id;
  logic                  rsp_deny_q, rsp_wr_q;

  assign cfg_wr   = cfg_en & cfg_we;
  assign clr_stat = cfg_wr & (cfg_addr == CFG_AW'(REG_CLEAR)) & cfg_wdata[0];
  assign clr_ovr  = cfg_wr & (cfg_addr == CFG_AW'(REG_CLEAR)) & cfg_wdata[8];

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 2'd0;
    else if (cfg_wr && cfg_addr == CFG_AW'(REG_ACTION)) act_q <= cfg_wdata[1:0];
  end

  // Region table
  for (genvar r = 0; r < NR; r++) begin : g_rgn
    localparam int A = REG_RGN0 + RGN_STRIDE * r;
    logic        srd_r, swr_r;
    logic [31:0] ida_r;
    if (r == 0) begin : g_dflt
      assign base_q[r] = '0;
      assign top_q[r]  = '1;
      assign en_q[r]   = 1'b1;
    end else begin : g_prog
      logic [AW-1:0] b_r, t_r;
      logic          e_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          b_r <= '0;
          t_r <= '0;
          e_r <= 1'b0;
        end else begin
          if (cfg_wr && cfg_addr == CFG_AW'(A))     b_r <= cfg_wdata[AW-1:0];
          if (cfg_wr && cfg_addr == CFG_AW'(A + 1)) t_r <= cfg_wdata[AW-1:0];
          if (cfg_wr && cfg_addr == CFG_AW'(A + 2)) e_r <= cfg_wdata[0];
        end
      end
      assign base_q[r] = b_r;
      assign top_q[r]  = t_r;
      assign en_q[r]   = e_r;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srd_r <= 1'b0;
        swr_r <= 1'b0;
        ida_r <= '0;
      end else begin
        if (cfg_wr && cfg_addr == CFG_AW'(A + 2)) begin
          srd_r <= cfg_wdata[30];
          swr_r <= cfg_wdata[31];
        end
        if (cfg_wr && cfg_addr == CFG_AW'(A + 3)) ida_r <= cfg_wdata;
      end
    end
    assign srd_q[r] = srd_r;
    assign swr_q[r] = swr_r;
    assign ida_q[r] = ida_r;
  end

  rfilt_match #(.NR(NR), .AW(AW), .IW(IW)) u_match (
    .addr(req_addr), .base(base_q), .top(top_q), .en(en_q), .win(win)
  );

  rfilt_perm u_perm (
    .secure(req_secure), .write(req_write), .id(req_id),
    .srd(srd_q[win]), .swr(swr_q[win]), .ida(ida_q[win]), .allow(allow)
  );

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign viol      = accept & ~allow;

  assign mem_en    = accept & allow;
  assign mem_we    = req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  rfilt_faillog #(.AW(AW)) u_fail (
    .clk(clk), .rst_n(rst_n), .viol(viol), .addr(req_addr), .write(req_write),
    .secure(req_secure), .priv(req_priv), .id(req_id),
    .clr_stat(clr_stat), .clr_ovr(clr_ovr),
    .status(fail_status), .overrun(fail_overrun),
    .f_addr(f_addr), .f_ctl(f_ctl), .f_id(f_id), .first_hit(first_hit)
  );

  // Response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_deny_q <= 1'b0;
      rsp_wr_q   <= 1'b0;
      rsp_err    <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_deny_q <= ~allow;
      rsp_wr_q   <= req_write;
      rsp_err    <= ~allow & act_q[0];
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
    end
  end

  assign rsp_rdata = (rsp_valid & ~rsp_deny_q & ~rsp_wr_q) ? mem_rdata : '0;
  assign irq       = fail_status & act_q[1];

  // Configuration read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      CFG_AW'(REG_BUILD):  cfg_rdata = build_word(NR, AW);
      CFG_AW'(REG_ACTION): cfg_rdata = {30'd0, act_q};
      CFG_AW'(REG_STATUS): cfg_rdata = {23'd0, fail_overrun, 7'd0, fail_status};
      CFG_AW'(REG_FADDR):  cfg_rdata = 32'(f_addr);
      CFG_AW'(REG_FCTL):   cfg_rdata = f_ctl;
      CFG_AW'(REG_FID):    cfg_rdata = {28'd0, f_id};
      default: ;
    endcase
    for (int r = 0; r < NR; r++) begin
      if (cfg_addr == CFG_AW'(REG_RGN0 + RGN_STRIDE * r))     cfg_rdata = 32'(base_q[r]);
      if (cfg_addr == CFG_AW'(REG_RGN0 + RGN_STRIDE * r + 1)) cfg_rdata = 32'(top_q[r]);
      if (cfg_addr == CFG_AW'(REG_RGN0 + RGN_STRIDE * r + 2))
        cfg_rdata = {swr_q[r], srd_q[r], 29'd0, en_q[r]};
      if (cfg_addr == CFG_AW'(REG_RGN0 + RGN_STRIDE * r + 3)) cfg_rdata = ida_q[r];
    end
  end
endmodule

// File: rtl/rfilt_chk.sv
module rfilt_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          viol,
  input logic          first_hit,
  input logic [1:0]    act_q,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic          status,
  input logic          overrun,
  input logic          clr_stat,
  input logic [AW-1:0] f_addr,
  input logic          irq
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);                                      // R9
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);                  // R9
  AST_DENY_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (rsp_rdata == '0));                                // R5
  AST_DENY_ERR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && act_q[0]) |=> rsp_err);                            // R4
  AST_PASS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !viol) |=> !rsp_err);                            // R4
  AST_FIRST_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit |=> status);                                      // R7
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_stat) |=> $stable(f_addr));                 // R7
  AST_LATER_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_stat && viol) |=> overrun);                 // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> !irq);                                          // R7
endmodule

bind mem_region_filter rfilt_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .viol(viol), .first_hit(first_hit),
  .act_q(act_q), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .status(fail_status),
  .overrun(fail_overrun), .clr_stat(clr_stat), .f_addr(f_addr), .irq(irq)
);

// File: tb/tb_mem_region_filter.sv
module tb_mem_region_filter;
  localparam int NR = 4, AW = 32, DW = 32, CFG_AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_id = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic cfg_en = 0, cfg_we = 0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mem_en, mem_we, irq;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [31:0] cfg_rdata;

  int nvec = 0, nerr = 0;

  always #10 clk = ~clk;

  mem_region_filter #(.NR(NR), .AW(AW), .DW(DW), .CFG_AW(CFG_AW)) dut (.*);

  // Environment memory driven by the design's memory port
  logic [31:0] env_mem [256];
  logic [31:0] env_rd = '0;
  assign mem_rdata = env_rd;
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) env_mem[mem_addr[7:0]] <= mem_wdata;
      else env_rd <= env_mem[mem_addr[7:0]];
    end

  // Reference model state
  logic [31:0] ref_mem [256];
  logic [31:0] m_base[NR], m_top[NR], m_ida[NR];
  logic m_en[NR], m_srd[NR], m_swr[NR];
  logic [1:0] m_act;
  logic m_st, m_ov, m_rv, m_rdeny, m_rwr, m_rerr;
  logic [31:0] m_fa, m_fc, m_fid, m_rdata;

  initial for (int i = 0; i < 256; i++) begin
    env_mem[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
    ref_mem[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
  end

  function automatic bit m_allow(logic [31:0] a, logic wr, logic sec, logic [3:0] id);
    int pick = 0;
    bit found = 0;
    for (int r = NR - 1; r >= 0; r--)
      if (!found && (r == 0 || (m_en[r] && a >= m_base[r] && a <= m_top[r]))) begin
        pick = r; found = 1;
      end
    if (sec) return wr ? m_swr[pick] : m_srd[pick];
    return wr ? m_ida[pick][16 + id] : m_ida[pick][id];
  endfunction

  function automatic logic [31:0] m_cfg(int a);
    int r, k;
    case (a)
      0: return (32'(NR - 1)) | (32'(AW - 1) << 8);
      1: return {30'd0, m_act};
      2: return (m_ov ? 32'h100 : 32'h0) | (m_st ? 32'h1 : 32'h0);
      4: return m_fa;
      5: return m_fc;
      6: return m_fid;
      default: ;
    endcase
    if (a < 16) return 0;
    r = (a - 16) / 4; k = (a - 16) % 4;
    if (r >= NR) return 0;
    case (k)
      0: return (r == 0) ? 32'h0 : m_base[r];
      1: return (r == 0) ? 32'hFFFF_FFFF : m_top[r];
      2: return (m_swr[r] ? 32'h8000_0000 : 0) | (m_srd[r] ? 32'h4000_0000 : 0)
                | ((r == 0 || m_en[r]) ? 32'h1 : 0);
      default: return m_ida[r];
    endcase
  endfunction

  function automatic string cfg_tag(int a);
    if (a == 0) return "R8";
    if (a == 1) return "R4";
    if (a <= 3) return "R7";
    if (a <= 6) return "R6";
    return "R1";
  endfunction

  always @(posedge clk) begin
    bit acc, ok, clr_s, clr_o, st, ov;
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) begin
        m_base[r] = 0; m_top[r] = 0; m_ida[r] = 0; m_en[r] = 0; m_srd[r] = 0; m_swr[r] = 0;
      end
      m_act = 0; m_st = 0; m_ov = 0; m_rv = 0; m_rdeny = 0; m_rwr = 0; m_rerr = 0;
      m_fa = 0; m_fc = 0; m_fid = 0; m_rdata = 0;
    end else begin
      acc   = req_valid && (!m_rv || rsp_ready);
      ok    = m_allow(req_addr, req_write, req_secure, req_id);
      clr_s = cfg_en && cfg_we && cfg_addr == 3 && cfg_wdata[0];
      clr_o = cfg_en && cfg_we && cfg_addr == 3 && cfg_wdata[8];
      if (acc) begin
        m_rv = 1; m_rdeny = !ok; m_rwr = req_write; m_rerr = !ok && m_act[0];
        m_rdata = ref_mem[req_addr[7:0]];
        if (ok && req_write) ref_mem[req_addr[7:0]] = req_wdata;
      end else if (rsp_ready) begin
        m_rv = 0; m_rerr = 0;
      end
      st = m_st && !clr_s;
      ov = m_ov && !clr_o;
      if (acc && !ok) begin
        if (!st) begin
          st = 1; m_fa = req_addr; m_fid = {28'd0, req_id};
          m_fc = {7'd0, req_write, 2'd0, !req_secure, req_priv, 20'd0};
        end else ov = 1;
      end
      m_st = st; m_ov = ov;
      if (cfg_en && cfg_we) begin
        if (cfg_addr == 1) m_act = cfg_wdata[1:0];
        for (int r = 0; r < NR; r++) begin
          if (cfg_addr == 16 + 4 * r && r > 0) m_base[r] = cfg_wdata;
          if (cfg_addr == 17 + 4 * r && r > 0) m_top[r] = cfg_wdata;
          if (cfg_addr == 18 + 4 * r) begin
            m_swr[r] = cfg_wdata[31]; m_srd[r] = cfg_wdata[30];
            if (r > 0) m_en[r] = cfg_wdata[0];
          end
          if (cfg_addr == 19 + 4 * r) m_ida[r] = cfg_wdata;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit e_rdy, e_en;
    e_rdy = !m_rv || rsp_ready;
    e_en  = req_valid && e_rdy && m_allow(req_addr, req_write, req_secure, req_id);
    chk("R9 req_ready", 32'(req_ready), 32'(e_rdy));
    chk("R9 rsp_valid", 32'(rsp_valid), 32'(m_rv));
    chk("R4 rsp_err", 32'(rsp_err && rsp_valid), 32'(m_rerr && m_rv));
    chk("R5 rsp_rdata", rsp_rdata, (m_rv && !m_rdeny && !m_rwr) ? m_rdata : 32'h0);
    chk("R7 irq", 32'(irq), 32'(m_st && m_act[1]));
    chk("R1/R2/R3 mem_en", 32'(mem_en), 32'(e_en));
    if (e_en) begin
      chk("R5 mem_addr", mem_addr, req_addr);
      chk("R5 mem_we", 32'(mem_we), 32'(req_write));
      if (req_write) chk("R5 mem_wdata", mem_wdata, req_wdata);
    end
    chk(cfg_tag(int'(cfg_addr)), cfg_rdata, m_cfg(int'(cfg_addr)));
  end

  task automatic cyc(); @(negedge clk); #1; endtask

  task automatic cfg_w(int a, logic [31:0] d);
    cfg_en = 1; cfg_we = 1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
    cyc(); cfg_en = 0; cfg_we = 0; cfg_wdata = 0;
  endtask

  task automatic cfg_r(int a);
    cfg_en = 1; cfg_we = 0; cfg_addr = CFG_AW'(a);
    cyc(); cfg_en = 0;
  endtask

  task automatic acc(logic [31:0] a, bit wr, bit sec, bit priv, logic [3:0] id, logic [31:0] d);
    req_valid = 1; req_addr = a; req_write = wr; req_secure = sec; req_priv = priv;
    req_id = id; req_wdata = d;
    cyc(); req_valid = 0;
    cyc();
  endtask

  task automatic read_status();
    cfg_r(2); cfg_r(4); cfg_r(5); cfg_r(6);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cyc();
    // R10: reset state read back at the ports
    chk("R10 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R10 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 32; a++) cfg_r(a);
    cfg_addr = CFG_AW'(18);
    #1 chk("R10 region0 attr", cfg_rdata, 32'h1);

    // R10/R6: every access denied after reset, no signalling with action 0
    acc(32'h10, 0, 0, 1, 4'd2, 0);
    read_status();
    acc(32'h14, 1, 1, 0, 4'd7, 32'h1234);   // R7: overrun
    read_status();
    cfg_w(3, 32'h101);
    read_status();

    // R2/R3: region 0 permissions, action both
    cfg_w(18, 32'hC000_0000);
    cfg_w(19, (32'h1 << 2) | (32'h1 << 21));
    cfg_w(1, 32'd3);
    acc(32'h20, 1, 1, 0, 4'd0, 32'hCAFE_0001);
    acc(32'h20, 0, 1, 0, 4'd0, 0);
    acc(32'h21, 0, 0, 0, 4'd2, 0);
    acc(32'h22, 0, 0, 1, 4'd3, 0);          // denied: err + irq
    read_status();
    acc(32'h23, 1, 0, 0, 4'd5, 32'hBEEF_0005);
    acc(32'h23, 1, 0, 0, 4'd2, 32'hDEAD_0002); // denied write, overrun
    acc(32'h23, 0, 1, 0, 4'd0, 0);
    read_status();
    cfg_w(3, 32'h1);
    cfg_r(2);
    cfg_w(3, 32'h100);
    cfg_r(2);

    // R1: overlapping regions, inclusive bounds, highest wins
    cfg_w(20, 32'h30); cfg_w(21, 32'h60); cfg_w(22, 32'hC000_0001); cfg_w(23, 32'hFFFF_FFFF);
    cfg_w(24, 32'h40); cfg_w(25, 32'h4F); cfg_w(26, 32'h4000_0001); cfg_w(27, 32'h0);
    cfg_w(18, 32'h0);
    for (int a = 16; a < 32; a++) cfg_r(a);
    acc(32'h2F, 0, 1, 0, 0, 0);
    acc(32'h30, 0, 1, 0, 0, 0);
    acc(32'h3F, 1, 0, 0, 4'd9, 32'h0909_0909);
    acc(32'h40, 1, 1, 0, 0, 32'h4040_4040);
    acc(32'h40, 0, 1, 0, 0, 0);
    acc(32'h4F, 0, 0, 0, 4'd1, 0);
    acc(32'h50, 0, 0, 1, 4'd15, 0);
    acc(32'h60, 1, 1, 1, 0, 32'h6060_6060);
    acc(32'h61, 0, 1, 0, 0, 0);
    cfg_w(22, 32'hC000_0000);               // disable region 1
    acc(32'h50, 0, 1, 0, 0, 0);
    read_status();

    // R4: action codes 1 and 2
    cfg_w(3, 32'h101);
    cfg_w(1, 32'd1);
    acc(32'h61, 0, 0, 0, 4'd4, 0);
    cfg_w(3, 32'h101);
    cfg_w(1, 32'd2);
    acc(32'h62, 1, 0, 1, 4'd6, 32'h1);
    read_status();
    cfg_w(1, 32'd0);
    cfg_r(2);

    // R7: clear in the same cycle as a denial
    cfg_en = 1; cfg_we = 1; cfg_addr = CFG_AW'(3); cfg_wdata = 32'h101;
    req_valid = 1; req_addr = 32'h77; req_write = 0; req_secure = 0; req_id = 4'd8; req_priv = 1;
    cyc();
    cfg_en = 0; cfg_we = 0; req_valid = 0;
    read_status();

    // R9: response back-pressure
    cfg_w(18, 32'hC000_0000);
    rsp_ready = 0;
    req_valid = 1; req_addr = 32'h05; req_write = 0; req_secure = 1;
    cyc(); cyc(); cyc();
    rsp_ready = 1;
    req_addr = 32'h06;
    cyc();
    req_valid = 0;
    cyc(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule